// File: doc/BRIEF.md
# Deinterlacer Control and Status Register Bank

This block is the software-facing register bank of a video deinterlacing engine. A host reaches it through a simple register bus. Writes take effect in one cycle. Reads return their data one cycle after the request. The bank holds the frame geometry, the two frame-buffer base addresses, the pixel colour format, the algorithm code and a field-ID inversion flag. It drives all of these to the engine as steady configuration outputs.

The bank also runs the start/done handshake with the engine. A start bit stays high until the engine signals ready. A sticky done flag is captured from the engine's one-cycle completion pulse and is cleared by the host's read of the control word. An auto-restart option re-arms start each time the engine completes. Two event channels (completion and ready) each have an enable bit and a status bit. A single interrupt line is the global enable gated with any pending status bit.

Top module: `deintCsrTop`

## Requirements
- R1: After reset every register is zero. The engine start output, every configuration output and the interrupt line are all low, and a read of any offset returns 0.
- R2: Writes to the configuration offsets store only their defined bits and drive them out unchanged: width at 0x10 (bits 15:0), height at 0x18 (bits 15:0), read base at 0x20 (32 bits), write base at 0x28 (32 bits), colour format at 0x30 (bits 7:0), algorithm at 0x38 (bits 7:0; 0 median, 1 bob, 2 weave, 3 vertical-temporal, 6 pass-through), field inversion at 0x40 (bit 0). A read of each offset returns the stored value, and the configuration outputs change only on a write.
- R3: Any offset not listed in R2, R4, R9 or R10 reads as 0. A write to such an offset changes no register.
- R4: The control word is at offset 0x00. Writing it loads start (bit 0) and auto-restart (bit 7). Start is high when bit 0 reads as 1, and it is driven on the engine start output. Start stays high until the engine asserts ready while start is high; start is then low from the next cycle.
- R5: With auto-restart set and no write to the control word, an engine done pulse sets start in the next cycle. This takes priority over the ready-handshake clear.
- R6: A one-cycle engine done pulse sets the done flag (control bit 1). A read of offset 0x00 returns the flag and clears it, so the following read returns bit 1 as 0.
- R7: A done pulse in the same cycle as a control-word read leaves the done flag set. That read returns the old value.
- R8: Control bits 2 and 3 return the engine idle and engine ready inputs as sampled in the cycle of the read request.
- R9: The global interrupt enable is offset 0x04, bit 0. The channel enables are offset 0x08: bit 0 for done, bit 1 for ready. A channel's status bit at offset 0x0C sets on its event (done pulse, or ready high) only while that channel's enable bit is 1.
- R10: Writing 1 to a status bit at 0x0C toggles it, and writing 0 leaves it alone. An event in the same cycle as the write leaves its bit set.
- R11: The interrupt output is high exactly when the global enable is 1 and at least one status bit is 1.
- R12: Read data and its valid flag appear in the cycle after the read request. Read data holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write request |
| wrAddr | input | ADDR_W | Write byte offset |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Register read request |
| rdAddr | input | ADDR_W | Read byte offset |
| rdData | output | DATA_W | Read data, one cycle after request |
| rdValid | output | 1 | Read data valid |
| engDone | input | 1 | Engine completion pulse |
| engIdle | input | 1 | Engine idle level |
| engReady | input | 1 | Engine ready for a new start |
| engStart | output | 1 | Start request to the engine |
| cfgWidth | output | DIM_W | Frame width |
| cfgHeight | output | DIM_W | Frame height |
| cfgRdBase | output | DATA_W | Read frame-buffer base |
| cfgWrBase | output | DATA_W | Write frame-buffer base |
| cfgColorFmt | output | CODE_W | Colour format code |
| cfgAlgo | output | CODE_W | Algorithm code |
| cfgFieldInv | output | 1 | Field-ID inversion |
| irq | output | 1 | Interrupt line |

## Verification
The bench targets collisions between side effects. A done pulse that lands on the clearing read would lose the completion if clear won. A status event during a toggle write would drop the event if the toggle were applied last. An auto-restart re-arm coinciding with ready would deadlock the engine if the handshake clear won. It also writes to reserved offsets and oversized values into narrow fields. A design that decoded loosely would alias those writes into live registers or return stray upper bits.

// File: rtl/deintCsrPkg.sv
package deintCsrPkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_GIE, SEL_IER, SEL_ISR, SEL_WIDTH, SEL_HEIGHT,
    SEL_RDBASE, SEL_WRBASE, SEL_FMT, SEL_ALGO, SEL_FIELD
  } regSel_t;

  typedef struct packed {
    logic ctrlWr;
    logic gieWr;
    logic ierWr;
    logic isrWr;
    logic widthWr;
    logic heightWr;
    logic rdBaseWr;
    logic wrBaseWr;
    logic fmtWr;
    logic algoWr;
    logic fieldWr;
    logic ctrlRd;
    logic anyRd;
  } csrStrobes_t;

  function automatic regSel_t decodeOffset(input logic [15:0] off);
    case (off)
      16'h0000: decodeOffset = SEL_CTRL;
      16'h0004: decodeOffset = SEL_GIE;
      16'h0008: decodeOffset = SEL_IER;
      16'h000C: decodeOffset = SEL_ISR;
      16'h0010: decodeOffset = SEL_WIDTH;
      16'h0018: decodeOffset = SEL_HEIGHT;
      16'h0020: decodeOffset = SEL_RDBASE;
      16'h0028: decodeOffset = SEL_WRBASE;
      16'h0030: decodeOffset = SEL_FMT;
      16'h0038: decodeOffset = SEL_ALGO;
      16'h0040: decodeOffset = SEL_FIELD;
      default:  decodeOffset = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/deintCsrDecode.sv
module deintCsrDecode
  import deintCsrPkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output csrStrobes_t       stb,
  output regSel_t           rdSel
);
  regSel_t wrSel;

  always_comb begin
    wrSel = decodeOffset(16'(wrAddr));
    rdSel = decodeOffset(16'(rdAddr));
    stb = '0;
    if (wrEn) begin
      case (wrSel)
        SEL_CTRL:   stb.ctrlWr   = 1'b1;
        SEL_GIE:    stb.gieWr    = 1'b1;
        SEL_IER:    stb.ierWr    = 1'b1;
        SEL_ISR:    stb.isrWr    = 1'b1;
        SEL_WIDTH:  stb.widthWr  = 1'b1;
        SEL_HEIGHT: stb.heightWr = 1'b1;
        SEL_RDBASE: stb.rdBaseWr = 1'b1;
        SEL_WRBASE: stb.wrBaseWr = 1'b1;
        SEL_FMT:    stb.fmtWr    = 1'b1;
        SEL_ALGO:   stb.algoWr   = 1'b1;
        SEL_FIELD:  stb.fieldWr  = 1'b1;
        default:    ;
      endcase
    end
    stb.anyRd  = rdEn;
    stb.ctrlRd = rdEn && (rdSel == SEL_CTRL);
  end
endmodule

// File: rtl/deintCsrRegs.sv
module deintCsrRegs
  import deintCsrPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIM_W  = 16,
  parameter int CODE_W = 8,
  parameter int CHAN_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobes_t       stb,
  input  regSel_t           rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              engDone,
  input  logic              engIdle,
  input  logic              engReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              engStart,
  output logic [DIM_W-1:0]  cfgWidth,
  output logic [DIM_W-1:0]  cfgHeight,
  output logic [DATA_W-1:0] cfgRdBase,
  output logic [DATA_W-1:0] cfgWrBase,
  output logic [CODE_W-1:0] cfgColorFmt,
  output logic [CODE_W-1:0] cfgAlgo,
  output logic              cfgFieldInv,
  output logic              irq
);
  localparam int AUTO_BIT = 7;

  logic              startBit, doneFlag, autoRe, gieBit;
  logic [CHAN_N-1:0] ierBits, isrBits, chanEvent;
  logic [DATA_W-1:0] rdNext;

  assign chanEvent = CHAN_N'({engReady, engDone}) & ierBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startBit <= 1'b0;
      doneFlag <= 1'b0;
      autoRe   <= 1'b0;
    end else begin
      if (stb.ctrlWr) begin
        startBit <= wrData[0];
        autoRe   <= wrData[AUTO_BIT];
      end else if (autoRe && engDone) begin
        startBit <= 1'b1;
      end else if (startBit && engReady) begin
        startBit <= 1'b0;
      end
      if (engDone)         doneFlag <= 1'b1;
      else if (stb.ctrlRd) doneFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gieBit  <= 1'b0;
      ierBits <= '0;
      isrBits <= '0;
    end else begin
      if (stb.gieWr) gieBit  <= wrData[0];
      if (stb.ierWr) ierBits <= wrData[CHAN_N-1:0];
      isrBits <= (isrBits ^ (stb.isrWr ? wrData[CHAN_N-1:0] : '0)) | chanEvent;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWidth    <= '0;
      cfgHeight   <= '0;
      cfgRdBase   <= '0;
      cfgWrBase   <= '0;
      cfgColorFmt <= '0;
      cfgAlgo     <= '0;
      cfgFieldInv <= 1'b0;
    end else begin
      if (stb.widthWr)  cfgWidth    <= wrData[DIM_W-1:0];
      if (stb.heightWr) cfgHeight   <= wrData[DIM_W-1:0];
      if (stb.rdBaseWr) cfgRdBase   <= wrData;
      if (stb.wrBaseWr) cfgWrBase   <= wrData;
      if (stb.fmtWr)    cfgColorFmt <= wrData[CODE_W-1:0];
      if (stb.algoWr)   cfgAlgo     <= wrData[CODE_W-1:0];
      if (stb.fieldWr)  cfgFieldInv <= wrData[0];
    end
  end

  always_comb begin
    rdNext = '0;
    case (rdSel)
      SEL_CTRL: begin
        rdNext[0]        = startBit;
        rdNext[1]        = doneFlag;
        rdNext[2]        = engIdle;
        rdNext[3]        = engReady;
        rdNext[AUTO_BIT] = autoRe;
      end
      SEL_GIE:    rdNext[0] = gieBit;
      SEL_IER:    rdNext[CHAN_N-1:0] = ierBits;
      SEL_ISR:    rdNext[CHAN_N-1:0] = isrBits;
      SEL_WIDTH:  rdNext[DIM_W-1:0] = cfgWidth;
      SEL_HEIGHT: rdNext[DIM_W-1:0] = cfgHeight;
      SEL_RDBASE: rdNext = cfgRdBase;
      SEL_WRBASE: rdNext = cfgWrBase;
      SEL_FMT:    rdNext[CODE_W-1:0] = cfgColorFmt;
      SEL_ALGO:   rdNext[CODE_W-1:0] = cfgAlgo;
      SEL_FIELD:  rdNext[0] = cfgFieldInv;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.anyRd;
      if (stb.anyRd) rdData <= rdNext;
    end
  end

  assign engStart = startBit;
  assign irq      = gieBit && (|isrBits);
endmodule

// File: rtl/deintCsrTop.sv
module deintCsrTop
  import deintCsrPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int DIM_W  = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              engDone,
  input  logic              engIdle,
  input  logic              engReady,
  output logic              engStart,
  output logic [DIM_W-1:0]  cfgWidth,
  output logic [DIM_W-1:0]  cfgHeight,
  output logic [DATA_W-1:0] cfgRdBase,
  output logic [DATA_W-1:0] cfgWrBase,
  output logic [CODE_W-1:0] cfgColorFmt,
  output logic [CODE_W-1:0] cfgAlgo,
  output logic              cfgFieldInv,
  output logic              irq
);
  csrStrobes_t stb;
  regSel_t     rdSel;

  deintCsrDecode #(.ADDR_W(ADDR_W)) decode_i (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn), .rdAddr(rdAddr),
    .stb(stb), .rdSel(rdSel)
  );

  deintCsrRegs #(.DATA_W(DATA_W), .DIM_W(DIM_W), .CODE_W(CODE_W), .CHAN_N(2)) regs_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wrData(wrData),
    .engDone(engDone), .engIdle(engIdle), .engReady(engReady),
    .rdData(rdData), .rdValid(rdValid), .engStart(engStart),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .cfgRdBase(cfgRdBase),
    .cfgWrBase(cfgWrBase), .cfgColorFmt(cfgColorFmt), .cfgAlgo(cfgAlgo),
    .cfgFieldInv(cfgFieldInv), .irq(irq)
  );
endmodule

// File: rtl/deintCsrChecker.sv
module deintCsrChecker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int DIM_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              engIdle,
  input logic              engReady,
  input logic              engStart,
  input logic [DIM_W-1:0]  cfgWidth,
  input logic [DATA_W-1:0] cfgRdBase,
  input logic              irq
);
  logic rdReserved;
  always_comb begin
    case (16'(rdAddr))
      16'h00, 16'h04, 16'h08, 16'h0C, 16'h10, 16'h18,
      16'h20, 16'h28, 16'h30, 16'h38, 16'h40: rdReserved = 1'b0;
      default: rdReserved = 1'b1;
    endcase
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R12
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid); // R12
  AST_RESERVED_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdReserved) |=> (rdData == '0)); // R3
  AST_START_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && !engReady && !(wrEn && wrAddr == '0)) |=> engStart); // R4
  AST_CFG_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(cfgWidth) && $stable(cfgRdBase))); // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(4) && !wrData[0]) |=> !irq); // R11
  AST_IDLE_REPORTED: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == '0) |=> (rdData[2] == $past(engIdle))); // R8
endmodule

bind deintCsrTop deintCsrChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIM_W(DIM_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
  .engIdle(engIdle), .engReady(engReady), .engStart(engStart),
  .cfgWidth(cfgWidth), .cfgRdBase(cfgRdBase), .irq(irq)
);

// File: tb/deintCsrTop_tb_top.sv
`timescale 1ns/1ps
module deintCsrTop_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [6:0]  wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic        engDone = 1'b0, engIdle = 1'b0, engReady = 1'b0;
  logic [31:0] rdData, cfgRdBase, cfgWrBase;
  logic        rdValid, engStart, cfgFieldInv, irq;
  logic [15:0] cfgWidth, cfgHeight;
  logic [7:0]  cfgColorFmt, cfgAlgo;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  deintCsrTop dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .engDone(engDone), .engIdle(engIdle), .engReady(engReady), .engStart(engStart),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .cfgRdBase(cfgRdBase),
    .cfgWrBase(cfgWrBase), .cfgColorFmt(cfgColorFmt), .cfgAlgo(cfgAlgo),
    .cfgFieldInv(cfgFieldInv), .irq(irq)
  );

  // Behavioural reference: register values held as plain integers.
  int mStart, mDone, mAuto, mGie, mIer, mIsr, mW, mH, mFmt, mAlgo, mFld, mRv;
  logic [31:0] mRb, mWb, mRd, mView;

  function automatic logic [31:0] modelRead(input int off);
    case (off)
      'h00: return 32'(mStart + 2 * mDone + 4 * int'(engIdle) + 8 * int'(engReady) + 128 * mAuto);
      'h04: return 32'(mGie);
      'h08: return 32'(mIer);
      'h0C: return 32'(mIsr);
      'h10: return 32'(mW);
      'h18: return 32'(mH);
      'h20: return mRb;
      'h28: return mWb;
      'h30: return 32'(mFmt);
      'h38: return 32'(mAlgo);
      'h40: return 32'(mFld);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      {mStart, mDone, mAuto, mGie, mIer, mIsr, mW, mH, mFmt, mAlgo, mFld, mRv} = '{default: 0};
      mRb = 0; mWb = 0; mRd = 0;
    end else begin
      int evt, nStart;
      mRv = int'(rdEn);
      if (rdEn) mRd = modelRead(int'(rdAddr));
      evt = (engDone ? 1 : 0) + (engReady ? 2 : 0);
      nStart = mStart;
      if (wrEn && wrAddr == 0) nStart = int'(wrData[0]);
      else if (mAuto == 1 && engDone) nStart = 1;
      else if (mStart == 1 && engReady) nStart = 0;
      if (engDone) mDone = 1;
      else if (rdEn && rdAddr == 0) mDone = 0;
      if (wrEn && wrAddr == 'h0C) mIsr = mIsr ^ int'(wrData[1:0]);
      mIsr = mIsr | (evt & mIer);
      if (wrEn) begin
        case (int'(wrAddr))
          'h00: mAuto = int'(wrData[7]);
          'h04: mGie  = int'(wrData[0]);
          'h08: mIer  = int'(wrData[1:0]);
          'h10: mW    = int'(wrData[15:0]);
          'h18: mH    = int'(wrData[15:0]);
          'h20: mRb   = wrData;
          'h28: mWb   = wrData;
          'h30: mFmt  = int'(wrData[7:0]);
          'h38: mAlgo = int'(wrData[7:0]);
          'h40: mFld  = int'(wrData[0]);
          default: ;
        endcase
      end
      mStart = nStart;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference model.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R4 engStart", 32'(engStart), 32'(mStart));
      check("R11 irq", 32'(irq), 32'((mGie == 1 && mIsr != 0) ? 1 : 0));
      check("R12 rdValid", 32'(rdValid), 32'(mRv));
      check("R12 rdData", rdData, mRd);
      check("R2 width", 32'(cfgWidth), 32'(mW));
      check("R2 height", 32'(cfgHeight), 32'(mH));
      check("R2 rdBase", cfgRdBase, mRb);
      check("R2 wrBase", cfgWrBase, mWb);
      check("R2 fmt/algo/field", {cfgColorFmt, cfgAlgo, 15'd0, cfgFieldInv},
            {8'(mFmt), 8'(mAlgo), 15'd0, 1'(mFld)});
    end
  end

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk); wrEn = 1; wrAddr = 7'(off); wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input int off, output logic [31:0] d);
    @(negedge clk); rdEn = 1; rdAddr = 7'(off);
    @(negedge clk); rdEn = 0; d = rdData;
  endtask

  task automatic pulse(input bit isDone, input bit isReady);
    @(negedge clk); engDone = isDone; engReady = isReady;
    @(negedge clk); engDone = 0; engReady = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    foreach (mView[i]) ;
    for (int a = 0; a <= 'h44; a += 4) begin rd(a, v); check("R1 reset read", v, 32'h0); end
    check("R1 start/irq", {30'd0, engStart, irq}, 32'h0);
    // R2 configuration with oversized data
    wr('h10, 32'hABCD_1234); wr('h18, 32'hFFFF_0438);
    wr('h20, 32'hDEAD_BEEF); wr('h28, 32'h1234_5678);
    wr('h30, 32'h0000_01FF); wr('h38, 32'h0000_0003); wr('h40, 32'hFFFF_FFFF);
    rd('h10, v); check("R2 width read", v, 32'h1234);
    rd('h18, v); check("R2 height read", v, 32'h0438);
    rd('h30, v); check("R2 fmt read", v, 32'hFF);
    rd('h40, v); check("R2 field read", v, 32'h1);
    check("R2 algo out", 32'(cfgAlgo), 32'h3);
    wr('h38, 32'h6); check("R2 algo passthru", 32'(cfgAlgo), 32'h6);
    // R3 reserved offsets
    wr('h14, 32'hFFFF_FFFF); wr('h44, 32'hFFFF_FFFF); wr('h02, 32'hFFFF_FFFF);
    rd('h14, v); check("R3 reserved read", v, 32'h0);
    rd('h10, v); check("R3 width untouched", v, 32'h1234);
    rd('h00, v); check("R3 ctrl untouched", v, 32'h0);
    // R4 start and ready handshake
    wr('h00, 32'h1); check("R4 start set", 32'(engStart), 32'h1);
    repeat (3) @(negedge clk);
    check("R4 start held", 32'(engStart), 32'h1);
    pulse(0, 1); check("R4 start cleared", 32'(engStart), 32'h0);
    // R5 auto restart
    wr('h00, 32'h81); pulse(0, 1);
    check("R5 cleared by ready", 32'(engStart), 32'h0);
    pulse(1, 0); check("R5 rearmed", 32'(engStart), 32'h1);
    pulse(1, 1); check("R5 rearm beats clear", 32'(engStart), 32'h1);
    // R6 done read-clear
    rd('h00, v); check("R6 done seen", v, 32'h83);
    rd('h00, v); check("R6 done cleared", v, 32'h81);
    wr('h00, 32'h0);
    // R7 done pulse during read
    @(negedge clk); rdEn = 1; rdAddr = 0; engDone = 1;
    @(negedge clk); rdEn = 0; engDone = 0; v = rdData;
    check("R7 read returns old", v & 32'h2, 32'h0);
    rd('h00, v); check("R7 done kept", v & 32'h2, 32'h2);
    // R8 idle and ready bits
    engIdle = 1; rd('h00, v); check("R8 idle bit", v, 32'h4);
    @(negedge clk); engReady = 1; rdEn = 1; rdAddr = 0;
    @(negedge clk); engReady = 0; rdEn = 0; v = rdData;
    check("R8 ready bit", v, 32'hC);
    engIdle = 0;
    // R9 status enables
    pulse(1, 1); rd('h0C, v); check("R9 disabled no status", v, 32'h0);
    wr('h08, 32'h1); pulse(1, 0);
    rd('h0C, v); check("R9 done status", v, 32'h1);
    wr('h08, 32'h3); pulse(0, 1);
    rd('h0C, v); check("R9 ready status", v, 32'h3);
    // R10 toggle on write
    wr('h0C, 32'h1); rd('h0C, v); check("R10 toggle", v, 32'h2);
    wr('h0C, 32'h0); rd('h0C, v); check("R10 zero no effect", v, 32'h2);
    @(negedge clk); wrEn = 1; wrAddr = 'h0C; wrData = 32'h2; engReady = 1;
    @(negedge clk); wrEn = 0; engReady = 0;
    rd('h0C, v); check("R10 event wins", v, 32'h2);
    // R11 interrupt
    check("R11 irq no gie", 32'(irq), 32'h0);
    wr('h04, 32'h1); check("R11 irq on", 32'(irq), 32'h1);
    wr('h08, 32'h0); wr('h0C, 32'h2); check("R11 irq off", 32'(irq), 32'h0);
    wr('h04, 32'h0); rd('h04, v); check("R11 gie read", v, 32'h0);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule